// File: doc/BRIEF.md
# Prioritized Exception Entry Controller

This block sits next to a small processor core and decides, every clock, whether the core must leave its current flow for an exception. Seven request lines come in: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and software interrupt. The block masks the two interrupt lines against the disable bits of the current status word. It then selects the single most urgent request and performs the whole entry in one clock. Entry stores a return address in the link register of the target privileged mode and saves the old status word into that mode's saved-status register. It then writes the new mode and mask bits and issues a redirect to the exception's vector.

The core asks for a return with a single strobe. The block then redirects to the link register of the current mode and restores the status word from that mode's saved copy, with the normal-interrupt disable bit cleared. Only the link and saved-status registers are banked here. Instruction decode, the pipeline and the handler code belong to the core.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Request bit positions are 0 reset, 1 data abort, 2 fast interrupt, 3 normal interrupt, 4 prefetch abort, 5 undefined instruction, 6 software interrupt. The lowest eligible bit wins, and `taken_id_o` reports that bit index. Bits 5 and 6 are never raised together; if they are, bit 5 is served.
- R2: Target modes are encoded in status bits [4:0]: reset and software interrupt go to supervisor 10011; both aborts go to abort 10111; the fast interrupt goes to 10001; the normal interrupt goes to 10010; undefined goes to 11011. User mode is 10000.
- R3: The redirect address on entry is `VEC_BASE` plus a byte offset: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R4: Bit 0 is not affected by the mask bits and wins from any mode. A normal-interrupt request is ignored while status bit 7 is set. A fast-interrupt request is ignored while status bit 6 is set. A masked request does not block lower-priority ones.
- R5: Every entry sets status bit 7. Reset and fast interrupt also set bit 6; other sources leave bit 6 unchanged. Bit 5 is always written 0.
- R6: On entry the link register of the target mode receives `cur_pc_i + LR_OFS[id]` modulo 2^AW. A reset entry leaves the supervisor link register unchanged.
- R7: On entry the saved-status register of the target mode receives the status word held before the entry.
- R8: Entry and return take effect on the clock edge that samples the request. `taken_o` and `redirect_valid_o` are one-cycle pulses. `taken_id_o` and `redirect_pc_o` are zero whenever their strobe is low.
- R9: A return in a privileged mode redirects to that mode's link register. It loads the status word from that mode's saved-status register with bit 7 cleared. It pulses `redirect_valid_o` with `taken_o` low.
- R10: A return request is ignored when the current mode is not privileged, or when an eligible exception is accepted in the same cycle.
- R11: After `rst_ni` the status word is 0x10 (user mode, both masks clear), all banked registers are zero and both strobes are low.
- R12: `lr_o` and `spsr_o` show the banked registers of the current mode, and read zero in a non-privileged mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_req_i | input | 7 | Pending exception requests, one bit per source |
| cur_pc_i | input | AW | Address of the instruction in flight |
| ret_req_i | input | 1 | Request to return from the current exception |
| redirect_valid_o | output | 1 | Program counter redirect strobe |
| redirect_pc_o | output | AW | Redirect target |
| taken_o | output | 1 | Exception accepted strobe |
| taken_id_o | output | 3 | Index of the accepted source |
| status_o | output | 8 | Current status word: [7] irq disable, [6] fiq disable, [4:0] mode |
| lr_o | output | AW | Link register of the current mode |
| spsr_o | output | 8 | Saved status of the current mode |

## Verification
The bench builds the block with a 16-bit address, a vector base of 0x200 and link offsets of 2 and 6 for the undefined and software interrupt sources. These values make a swapped offset or a missing base visible in the compared values. A program counter near the top of the 16-bit range reaches the wrap of the return address. Directed sequences cover nested fast-over-normal entry, return chains back to user mode, a return together with an exception in the same cycle, and masked requests. A long random stretch then mixes all sources and returns against the behavioural model.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  localparam int unsigned NUM_SRC  = 7;
  localparam int unsigned ID_W     = 3;
  localparam int unsigned NUM_BANK = 5;
  localparam int unsigned BANK_W   = $clog2(NUM_BANK);
  localparam int unsigned STATUS_W = 8;

  localparam logic [ID_W-1:0] ID_RST  = 3'd0;
  localparam logic [ID_W-1:0] ID_DABT = 3'd1;
  localparam logic [ID_W-1:0] ID_FIQ  = 3'd2;
  localparam logic [ID_W-1:0] ID_IRQ  = 3'd3;
  localparam logic [ID_W-1:0] ID_PABT = 3'd4;
  localparam logic [ID_W-1:0] ID_UND  = 3'd5;
  localparam logic [ID_W-1:0] ID_SWI  = 3'd6;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;

  typedef struct packed {
    logic       irq_dis;
    logic       fiq_dis;
    logic       rsvd;
    logic [4:0] mode;
  } status_t;

  function automatic logic [4:0] exc_mode(logic [ID_W-1:0] id);
    case (id)
      ID_DABT, ID_PABT: return MODE_ABT;
      ID_FIQ:           return MODE_FIQ;
      ID_IRQ:           return MODE_IRQ;
      ID_UND:           return MODE_UND;
      default:          return MODE_SVC;
    endcase
  endfunction

  function automatic logic [7:0] exc_vec_ofs(logic [ID_W-1:0] id);
    case (id)
      ID_UND:  return 8'h04;
      ID_SWI:  return 8'h08;
      ID_PABT: return 8'h0C;
      ID_DABT: return 8'h10;
      ID_IRQ:  return 8'h18;
      ID_FIQ:  return 8'h1C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic is_priv(logic [4:0] mode);
    case (mode)
      MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] mode_bank(logic [4:0] mode);
    case (mode)
      MODE_IRQ: return BANK_W'(1);
      MODE_SVC: return BANK_W'(2);
      MODE_ABT: return BANK_W'(3);
      MODE_UND: return BANK_W'(4);
      default:  return BANK_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/exc_prio_sel.sv
`timescale 1ns/1ps
module exc_prio_sel
  import exc_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               irq_dis_i,
  input  logic               fiq_dis_i,
  output logic               valid_o,
  output logic [ID_W-1:0]    id_o
);
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] first;

  always_comb begin
    elig         = req_i;
    elig[ID_FIQ] = req_i[ID_FIQ] & ~fiq_dis_i;
    elig[ID_IRQ] = req_i[ID_IRQ] & ~irq_dis_i;
  end

  // lowest index = highest priority
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign first[i] = elig[i];
    end else begin : g_rest
      assign first[i] = elig[i] & ~|elig[i-1:0];
    end
  end

  always_comb begin
    id_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (first[i]) id_o = ID_W'(i);
    end
  end

  assign valid_o = |elig;
endmodule

// File: rtl/exc_bank_regs.sv
`timescale 1ns/1ps
module exc_bank_regs
  import exc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_lr_i,
  input  logic                wr_spsr_i,
  input  logic [BANK_W-1:0]   wr_sel_i,
  input  logic [AW-1:0]       lr_d_i,
  input  logic [STATUS_W-1:0] spsr_d_i,
  input  logic [BANK_W-1:0]   rd_sel_i,
  output logic [AW-1:0]       lr_q_o,
  output logic [STATUS_W-1:0] spsr_q_o
);
  logic [AW-1:0]       lr_all   [NUM_BANK];
  logic [STATUS_W-1:0] spsr_all [NUM_BANK];

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic [AW-1:0]       lr_q;
    logic [STATUS_W-1:0] spsr_q;
    logic                hit;

    assign hit = (wr_sel_i == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lr_q   <= '0;
        spsr_q <= '0;
      end else begin
        if (wr_lr_i && hit)   lr_q   <= lr_d_i;
        if (wr_spsr_i && hit) spsr_q <= spsr_d_i;
      end
    end

    assign lr_all[b]   = lr_q;
    assign spsr_all[b] = spsr_q;
  end

  logic rd_ok;
  assign rd_ok    = (32'(rd_sel_i) < NUM_BANK);
  assign lr_q_o   = rd_ok ? lr_all[rd_sel_i]   : '0;
  assign spsr_q_o = rd_ok ? spsr_all[rd_sel_i] : '0;
endmodule

// File: rtl/exc_status_ctrl.sv
`timescale 1ns/1ps
module exc_status_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned   AW               = 32,
  parameter logic [AW-1:0] VEC_BASE         = '0,
  parameter int unsigned   LR_OFS [NUM_SRC] = '{0, 8, 4, 4, 4, 4, 4}
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_valid_i,
  input  logic [ID_W-1:0]     sel_id_i,
  input  logic                ret_req_i,
  input  logic [AW-1:0]       cur_pc_i,
  input  logic [AW-1:0]       lr_rd_i,
  input  logic [STATUS_W-1:0] spsr_rd_i,
  output status_t             status_o,
  output logic                bank_wr_lr_o,
  output logic                bank_wr_spsr_o,
  output logic [BANK_W-1:0]   bank_wr_sel_o,
  output logic [AW-1:0]       bank_lr_d_o,
  output logic [STATUS_W-1:0] bank_spsr_d_o,
  output logic                redirect_valid_o,
  output logic [AW-1:0]       redirect_pc_o,
  output logic                taken_o,
  output logic [ID_W-1:0]     taken_id_o
);
  localparam status_t ST_RST = '{irq_dis: 1'b0, fiq_dis: 1'b0, rsvd: 1'b0, mode: MODE_USR};

  logic [AW-1:0] ofs_tbl [NUM_SRC];
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ofs
    assign ofs_tbl[i] = AW'(LR_OFS[i]);
  end

  status_t       st_q, st_d;
  logic          do_exc, do_ret;
  logic [4:0]    tgt_mode;
  logic          rv_d, tk_d;
  logic [AW-1:0] rpc_d;
  logic [ID_W-1:0] tid_d;

  assign tgt_mode = exc_mode(sel_id_i);
  assign do_exc   = sel_valid_i;
  assign do_ret   = ret_req_i & ~sel_valid_i & is_priv(st_q.mode);

  always_comb begin
    st_d  = st_q;
    rv_d  = 1'b0;
    tk_d  = 1'b0;
    rpc_d = '0;
    tid_d = '0;
    if (do_exc) begin
      st_d.mode    = tgt_mode;
      st_d.irq_dis = 1'b1;
      st_d.fiq_dis = st_q.fiq_dis | (sel_id_i == ID_RST) | (sel_id_i == ID_FIQ);
      st_d.rsvd    = 1'b0;
      rv_d         = 1'b1;
      tk_d         = 1'b1;
      tid_d        = sel_id_i;
      rpc_d        = VEC_BASE + AW'(exc_vec_ofs(sel_id_i));
    end else if (do_ret) begin
      st_d         = status_t'(spsr_rd_i);
      st_d.irq_dis = 1'b0;
      rv_d         = 1'b1;
      rpc_d        = lr_rd_i;
    end
  end

  assign bank_wr_sel_o  = mode_bank(tgt_mode);
  assign bank_wr_spsr_o = do_exc;
  assign bank_wr_lr_o   = do_exc & (sel_id_i != ID_RST);
  assign bank_lr_d_o    = cur_pc_i + ofs_tbl[sel_id_i];
  assign bank_spsr_d_o  = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q             <= ST_RST;
      redirect_valid_o <= 1'b0;
      redirect_pc_o    <= '0;
      taken_o          <= 1'b0;
      taken_id_o       <= '0;
    end else begin
      st_q             <= st_d;
      redirect_valid_o <= rv_d;
      redirect_pc_o    <= rpc_d;
      taken_o          <= tk_d;
      taken_id_o       <= tid_d;
    end
  end

  assign status_o = st_q;
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned   AW               = 32,
  parameter logic [AW-1:0] VEC_BASE         = '0,
  parameter int unsigned   LR_OFS [NUM_SRC] = '{0, 8, 4, 4, 4, 4, 4}
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  exc_req_i,
  input  logic [AW-1:0]       cur_pc_i,
  input  logic                ret_req_i,
  output logic                redirect_valid_o,
  output logic [AW-1:0]       redirect_pc_o,
  output logic                taken_o,
  output logic [ID_W-1:0]     taken_id_o,
  output logic [STATUS_W-1:0] status_o,
  output logic [AW-1:0]       lr_o,
  output logic [STATUS_W-1:0] spsr_o
);
  status_t             status;
  logic                sel_valid;
  logic [ID_W-1:0]     sel_id;
  logic                wr_lr, wr_spsr;
  logic [BANK_W-1:0]   wr_sel, rd_sel;
  logic [AW-1:0]       lr_d, lr_rd;
  logic [STATUS_W-1:0] spsr_d, spsr_rd;
  logic                priv;

  exc_prio_sel u_sel (
    .req_i     (exc_req_i),
    .irq_dis_i (status.irq_dis),
    .fiq_dis_i (status.fiq_dis),
    .valid_o   (sel_valid),
    .id_o      (sel_id)
  );

  exc_status_ctrl #(
    .AW       (AW),
    .VEC_BASE (VEC_BASE),
    .LR_OFS   (LR_OFS)
  ) u_ctrl (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .sel_valid_i      (sel_valid),
    .sel_id_i         (sel_id),
    .ret_req_i        (ret_req_i),
    .cur_pc_i         (cur_pc_i),
    .lr_rd_i          (lr_rd),
    .spsr_rd_i        (spsr_rd),
    .status_o         (status),
    .bank_wr_lr_o     (wr_lr),
    .bank_wr_spsr_o   (wr_spsr),
    .bank_wr_sel_o    (wr_sel),
    .bank_lr_d_o      (lr_d),
    .bank_spsr_d_o    (spsr_d),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o),
    .taken_o          (taken_o),
    .taken_id_o       (taken_id_o)
  );

  assign rd_sel = mode_bank(status.mode);
  assign priv   = is_priv(status.mode);

  exc_bank_regs #(.AW(AW)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lr_i   (wr_lr),
    .wr_spsr_i (wr_spsr),
    .wr_sel_i  (wr_sel),
    .lr_d_i    (lr_d),
    .spsr_d_i  (spsr_d),
    .rd_sel_i  (rd_sel),
    .lr_q_o    (lr_rd),
    .spsr_q_o  (spsr_rd)
  );

  assign status_o = status;
  assign lr_o     = priv ? lr_rd   : '0;
  assign spsr_o   = priv ? spsr_rd : '0;
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
`timescale 1ns/1ps
module exc_entry_ctrl_chk
  import exc_pkg::*;
#(
  parameter int unsigned   AW               = 32,
  parameter logic [AW-1:0] VEC_BASE         = '0,
  parameter int unsigned   LR_OFS [NUM_SRC] = '{0, 8, 4, 4, 4, 4, 4}
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_SRC-1:0]  exc_req_i,
  input logic [AW-1:0]       cur_pc_i,
  input logic                ret_req_i,
  input logic                redirect_valid_o,
  input logic [AW-1:0]       redirect_pc_o,
  input logic                taken_o,
  input logic [ID_W-1:0]     taken_id_o,
  input logic [STATUS_W-1:0] status_o,
  input logic [AW-1:0]       lr_o,
  input logic [STATUS_W-1:0] spsr_o
);
  a_r1_reset_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i[0] |=> (taken_o && taken_id_o == ID_RST));

  a_r2_irq_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && taken_id_o == ID_IRQ) |-> (status_o[4:0] == MODE_IRQ));

  a_r3_fiq_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && taken_id_o == ID_FIQ) |-> (redirect_pc_o == VEC_BASE + AW'(8'h1C)));

  a_r4_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[7] && exc_req_i == 7'b0001000) |=> !taken_o);

  a_r5_irq_dis_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> status_o[7]);

  a_r6_lr_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && taken_id_o != ID_RST) |-> (lr_o == $past(cur_pc_i) + AW'(LR_OFS[taken_id_o])));

  a_r7_spsr_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (spsr_o == $past(status_o)));

  a_r8_taken_redirects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> redirect_valid_o);

  a_r9_ret_unmasks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_req_i && exc_req_i == '0 && is_priv(status_o[4:0]))
      |=> (redirect_valid_o && !taken_o && !status_o[7]));

  a_r10_user_ret_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_req_i && exc_req_i == '0 && !is_priv(status_o[4:0])) |=> !redirect_valid_o);
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
  .AW       (AW),
  .VEC_BASE (VEC_BASE),
  .LR_OFS   (LR_OFS)
) u_chk (.*);

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;
  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] VB = 16'h0200;
  localparam int unsigned OFS [7] = '{0, 8, 4, 4, 4, 2, 6};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [6:0]    exc_req = '0;
  logic [AW-1:0] cur_pc = '0;
  logic          ret_req = 1'b0;
  logic          redirect_valid, taken;
  logic [AW-1:0] redirect_pc, lr;
  logic [2:0]    taken_id;
  logic [7:0]    status, spsr;

  always #2.5 clk = ~clk;

  exc_entry_ctrl #(.AW(AW), .VEC_BASE(VB), .LR_OFS(OFS)) u_exc_entry_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .exc_req_i(exc_req), .cur_pc_i(cur_pc),
    .ret_req_i(ret_req), .redirect_valid_o(redirect_valid), .redirect_pc_o(redirect_pc),
    .taken_o(taken), .taken_id_o(taken_id), .status_o(status), .lr_o(lr), .spsr_o(spsr)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural model
  int m_st = 'h10;
  int m_lr [32];
  int m_spsr [32];
  int m_rv = 0, m_rpc = 0, m_tk = 0, m_tid = 0;

  function automatic int mode_of(int id);
    case (id)
      1, 4: return 'b10111;
      2: return 'b10001;
      3: return 'b10010;
      5: return 'b11011;
      default: return 'b10011;
    endcase
  endfunction

  function automatic int vec_of(int id);
    case (id)
      0: return 'h00; 1: return 'h10; 2: return 'h1C; 3: return 'h18;
      4: return 'h0C; 5: return 'h04; default: return 'h08;
    endcase
  endfunction

  function automatic bit priv(int m);
    return (m == 'b10001 || m == 'b10010 || m == 'b10011 || m == 'b10111 || m == 'b11011);
  endfunction

  task automatic m_step(input logic [6:0] req, input int pc, input bit ret);
    int win = -1;
    int cm = m_st & 31;
    m_rv = 0; m_tk = 0; m_rpc = 0; m_tid = 0;
    for (int id = 0; id < 7; id++) begin
      if (win < 0 && req[id]) begin
        if (id == 2 && (m_st & 'h40) != 0) continue;
        if (id == 3 && (m_st & 'h80) != 0) continue;
        win = id;
      end
    end
    if (win >= 0) begin
      int tm = mode_of(win);
      int f = ((m_st & 'h40) != 0 || win == 0 || win == 2) ? 'h40 : 0;
      m_spsr[tm] = m_st;
      if (win != 0) m_lr[tm] = (pc + OFS[win]) & 'hFFFF;
      m_st = 'h80 | f | tm;
      m_rv = 1; m_tk = 1; m_tid = win;
      m_rpc = VB + vec_of(win);
    end else if (ret && priv(cm)) begin
      m_rpc = m_lr[cm];
      m_st = m_spsr[cm] & 'h7F;
      m_rv = 1;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string ctx);
    int cm = m_st & 31;
    chk({ctx, " R8 redirect_valid"}, redirect_valid, m_rv);
    chk({ctx, " R3/R9 redirect_pc"}, redirect_pc, m_rpc);
    chk({ctx, " R8 taken"}, taken, m_tk);
    chk({ctx, " R1 taken_id"}, taken_id, m_tid);
    chk({ctx, " R2/R5 status"}, status, m_st);
    chk({ctx, " R6/R12 lr"}, lr, priv(cm) ? m_lr[cm] : 0);
    chk({ctx, " R7/R12 spsr"}, spsr, priv(cm) ? m_spsr[cm] : 0);
  endtask

  task automatic step(input logic [6:0] req, input int pc, input bit ret, input string ctx);
    exc_req = req;
    cur_pc  = AW'(pc);
    ret_req = ret;
    m_step(req, pc, ret);
    @(posedge clk);
    @(negedge clk);
    compare_all(ctx);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin m_lr[i] = 0; m_spsr[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R11 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R11 after reset");

    step(7'b0001000, 'h0100, 0, "R2 irq entry");
    step(7'b0000000, 'h0104, 0, "R8 strobes drop");
    step(7'b0001000, 'h0108, 0, "R4 irq masked");
    step(7'b0001100, 'h010C, 0, "R4 fiq over masked irq");
    step(7'b0000000, 'h0200, 1, "R9 return from fiq");
    step(7'b0000000, 'h0204, 1, "R9 return from irq");
    step(7'b0000000, 'h0208, 1, "R10 user return ignored");
    step(7'b0000000, 'h020C, 0, "R12 user view");
    step(7'b1000000, 'h0300, 0, "R2 swi entry");
    step(7'b0100000, 'h0310, 0, "R6 und nested");
    step(7'b0010000, 'h0320, 1, "R10 exception beats return");
    step(7'b0000010, 'hFFFC, 0, "R6 dabt wrap");
    step(7'b0000000, 'h0000, 1, "R9 return from abort");
    step(7'b0111111, 'h0400, 0, "R1 all pending");
    step(7'b0000001, 'h0500, 0, "R6 reset keeps lr");
    step(7'b0011110, 'h0600, 0, "R1 dabt over rest");
    step(7'b0011100, 'h0604, 0, "R4 masked fiq irq skip");
    step(7'b0100000, 'h0608, 0, "R1 und lowest");
    step(7'b0000000, 'h0000, 1, "R9 return chain");

    for (int c = 0; c < 4000; c++) begin
      logic [6:0] r = '0;
      for (int b = 0; b < 7; b++) if ($urandom_range(7) == 0) r[b] = 1'b1;
      if ($urandom_range(15) != 0) r[0] = 1'b0;
      if (r[5] && r[6]) r[6] = 1'b0;
      step(r, int'($urandom_range(16'hFFFF)) & 'hFFFC, ($urandom_range(3) == 0), "R1 random mix");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R8 watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule